// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block resolves read-after-write data hazards in a five-stage, in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it compares the source register numbers of the instruction about to execute with the destinations held in the two younger pipeline registers. From that comparison it produces one operand-select code for each ALU input multiplexer. The code steers that input to the register value, to the ALU result waiting in the execute/memory register, or to the result waiting in the memory/write-back register.

A load produces its data only at the end of the memory stage. When the instruction in decode reads the destination of a load that is currently in execute, the unit raises a stall. The stall freezes the program counter and the fetch/decode register for one cycle and causes a no-op bubble to be loaded into the decode/execute register. After that bubble, the dependent instruction picks up the loaded value from the memory/write-back register.

A register file is part of the block. A write-back to a register and a decode-stage read of the same register in the same cycle return the new value. For this reason no third bypass path from write-back is needed. Register 0 is hard-wired to zero and never takes part in forwarding or stalling.

Top module: `hzd_bypass_unit`

## Requirements
- R1: When `exmem_wen` is 1, `exmem_rd` is nonzero and `exmem_rd` equals an execute-stage source, that operand's select is 2'b10.
- R2: When no EX/MEM match exists for a source, and `memwb_wen` is 1 with a nonzero `memwb_rd` equal to that source, the select is 2'b01.
- R3: When both the EX/MEM and the MEM/WB destinations match the same source, the select is 2'b10: the younger result wins.
- R4: With no qualifying match, a select is 2'b00. The two operand selects are decided independently of each other.
- R5: A source or destination of register 0 never yields a select other than 2'b00 and never causes a stall.
- R6: `stall` is 1 exactly when `idex_is_load` is 1, `idex_rd` is nonzero and `idex_rd` equals `ifid_rs_a` or `ifid_rs_b`. `bubble` always equals `stall`.
- R7: A matching `idex_rd` without `idex_is_load` does not stall.
- R8: On a rising clock edge with `memwb_wen` set and a nonzero `memwb_rd`, the register file stores `memwb_wdata`. Read ports return stored values combinationally.
- R9: When a read address equals a nonzero `memwb_rd` while `memwb_wen` is 1, the read returns `memwb_wdata` in that same cycle.
- R10: Reads of register 0 return zero, and writes to register 0 are discarded.
- R11: Reset (`rst_n` low, asynchronous) clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idex_rs_a | input | 5 | First source register of the instruction in ID/EX |
| idex_rs_b | input | 5 | Second source register of the instruction in ID/EX |
| idex_rd | input | 5 | Destination of the instruction in ID/EX |
| idex_is_load | input | 1 | Instruction in ID/EX is a load |
| ifid_rs_a | input | 5 | First source register of the instruction in IF/ID; register-file read address A |
| ifid_rs_b | input | 5 | Second source register of the instruction in IF/ID; register-file read address B |
| exmem_rd | input | 5 | Destination held in EX/MEM |
| exmem_wen | input | 1 | EX/MEM instruction writes a register |
| memwb_rd | input | 5 | Destination held in MEM/WB |
| memwb_wen | input | 1 | MEM/WB instruction writes a register |
| memwb_wdata | input | 32 | Write-back data |
| fwd_sel_a | output | 2 | Select for ALU operand A (00 register, 10 EX/MEM, 01 MEM/WB) |
| fwd_sel_b | output | 2 | Select for ALU operand B |
| stall | output | 1 | Hold PC and IF/ID this cycle |
| bubble | output | 1 | Load a no-op with cleared write enables into ID/EX |
| rf_rdata_a | output | 32 | Register-file read data A |
| rf_rdata_b | output | 32 | Register-file read data B |

## Verification
A directed producer-then-four-readers sequence walks one result through the EX/MEM bypass, the MEM/WB bypass, the same-cycle write-through and a plain register read. Each step separates one of the four data paths. A second pass drives random traffic over only four register numbers, so that the sources often hit both destinations at once. It also mixes write enables, so that it exposes a wrong priority (R3), cross-talk between the two operand selects and missing zero-register qualification. A load/non-load pair with the same matching destination tells the load-use interlock apart from an ordinary dependence.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      OPSEL_REG  = 2'b00,
      OPSEL_WB   = 2'b01,
      OPSEL_MEM  = 2'b10
   } opsel_e;
endpackage

// File: rtl/hzd_src_select.sv
module hzd_src_select #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] exmem_rd,
   input  logic          exmem_wen,
   input  logic [AW-1:0] memwb_rd,
   input  logic          memwb_wen,
   output hzd_pkg::opsel_e sel
);
   logic src_live, hit_mem, hit_wb;

   assign src_live = (src != '0);
   assign hit_mem  = src_live && exmem_wen && (exmem_rd == src);
   assign hit_wb   = src_live && memwb_wen && (memwb_rd == src);

   // younger result in EX/MEM has priority over MEM/WB
   always_comb begin
      if (hit_mem)     sel = hzd_pkg::OPSEL_MEM;
      else if (hit_wb) sel = hzd_pkg::OPSEL_WB;
      else             sel = hzd_pkg::OPSEL_REG;
   end
endmodule

// File: rtl/hzd_loaduse_detect.sv
module hzd_loaduse_detect #(
   parameter int AW   = 5,
   parameter int NSRC = 2
) (
   input  logic                      is_load,
   input  logic [AW-1:0]             load_rd,
   input  logic [NSRC-1:0][AW-1:0]   srcs,
   output logic                      hold
);
   logic [NSRC-1:0] match;

   for (genvar i = 0; i < NSRC; i++) begin : g_cmp
      assign match[i] = (srcs[i] == load_rd);
   end

   assign hold = is_load && (load_rd != '0) && (|match);
endmodule

// File: rtl/hzd_regfile.sv
module hzd_regfile #(
   parameter int XLEN       = 32,
   parameter int NREGS      = 32,
   parameter int NRD        = 2,
   parameter bit WRITE_THRU = 1'b1,
   localparam int AW        = $clog2(NREGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [XLEN-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]    raddr,
   output logic [NRD-1:0][XLEN-1:0]  rdata
);
   logic [XLEN-1:0] cells [NREGS];
   logic            wr_live;

   assign wr_live = we && (waddr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) cells[i] <= '0;
      end else if (wr_live) begin
         cells[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      if (WRITE_THRU) begin : g_thru
         always_comb begin
            if (raddr[p] == '0)                      rdata[p] = '0;
            else if (wr_live && waddr == raddr[p])   rdata[p] = wdata;
            else                                     rdata[p] = cells[raddr[p]];
         end
      end else begin : g_plain
         always_comb begin
            if (raddr[p] == '0) rdata[p] = '0;
            else                rdata[p] = cells[raddr[p]];
         end
      end
   end
endmodule

// File: rtl/hzd_bypass_unit.sv
module hzd_bypass_unit #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   idex_rs_a,
   input  logic [AW-1:0]   idex_rs_b,
   input  logic [AW-1:0]   idex_rd,
   input  logic            idex_is_load,
   input  logic [AW-1:0]   ifid_rs_a,
   input  logic [AW-1:0]   ifid_rs_b,
   input  logic [AW-1:0]   exmem_rd,
   input  logic            exmem_wen,
   input  logic [AW-1:0]   memwb_rd,
   input  logic            memwb_wen,
   input  logic [XLEN-1:0] memwb_wdata,
   output logic [1:0]      fwd_sel_a,
   output logic [1:0]      fwd_sel_b,
   output logic            stall,
   output logic            bubble,
   output logic [XLEN-1:0] rf_rdata_a,
   output logic [XLEN-1:0] rf_rdata_b
);
   localparam int NOPS = 2;

   if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_nregs
      $error("hzd_bypass_unit: NREGS must be a power of two of at least 2");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("hzd_bypass_unit: XLEN must be positive");
   end

   logic [NOPS-1:0][AW-1:0]   ex_srcs, id_srcs;
   logic [NOPS-1:0][1:0]      sels;
   logic [NOPS-1:0][XLEN-1:0] rd_words;
   logic                      hold;

   assign ex_srcs = {idex_rs_b, idex_rs_a};
   assign id_srcs = {ifid_rs_b, ifid_rs_a};

   for (genvar k = 0; k < NOPS; k++) begin : g_op
      hzd_pkg::opsel_e sel_k;
      hzd_src_select #(.AW(AW)) u_sel (
         .src       (ex_srcs[k]),
         .exmem_rd  (exmem_rd),
         .exmem_wen (exmem_wen),
         .memwb_rd  (memwb_rd),
         .memwb_wen (memwb_wen),
         .sel       (sel_k)
      );
      assign sels[k] = sel_k;
   end

   hzd_loaduse_detect #(.AW(AW), .NSRC(NOPS)) u_lu (
      .is_load (idex_is_load),
      .load_rd (idex_rd),
      .srcs    (id_srcs),
      .hold    (hold)
   );

   hzd_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NOPS), .WRITE_THRU(1'b1)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (memwb_wen),
      .waddr (memwb_rd),
      .wdata (memwb_wdata),
      .raddr (id_srcs),
      .rdata (rd_words)
   );

   assign fwd_sel_a  = sels[0];
   assign fwd_sel_b  = sels[1];
   assign stall      = hold;
   assign bubble     = hold;
   assign rf_rdata_a = rd_words[0];
   assign rf_rdata_b = rd_words[1];
endmodule

// File: rtl/hzd_bypass_chk.sv
module hzd_bypass_chk #(
   parameter int XLEN  = 32,
   parameter int AW    = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   idex_rs_a,
   input logic [AW-1:0]   idex_rs_b,
   input logic [AW-1:0]   idex_rd,
   input logic            idex_is_load,
   input logic [AW-1:0]   ifid_rs_a,
   input logic [AW-1:0]   ifid_rs_b,
   input logic [AW-1:0]   exmem_rd,
   input logic            exmem_wen,
   input logic [AW-1:0]   memwb_rd,
   input logic            memwb_wen,
   input logic [XLEN-1:0] memwb_wdata,
   input logic [1:0]      fwd_sel_a,
   input logic [1:0]      fwd_sel_b,
   input logic            stall,
   input logic            bubble,
   input logic [XLEN-1:0] rf_rdata_a,
   input logic [XLEN-1:0] rf_rdata_b
);
   a_r1_exmem_a: assert property (@(posedge clk) disable iff (!rst_n)
      (exmem_wen && exmem_rd != '0 && exmem_rd == idex_rs_a) |-> fwd_sel_a == 2'b10);
   a_r1_exmem_b: assert property (@(posedge clk) disable iff (!rst_n)
      (exmem_wen && exmem_rd != '0 && exmem_rd == idex_rs_b) |-> fwd_sel_b == 2'b10);
   a_r2_memwb_a: assert property (@(posedge clk) disable iff (!rst_n)
      (memwb_wen && memwb_rd != '0 && memwb_rd == idex_rs_a
       && !(exmem_wen && exmem_rd == idex_rs_a)) |-> fwd_sel_a == 2'b01);
   a_r5_zero_src_a: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_rs_a == '0) |-> fwd_sel_a == 2'b00);
   a_r5_zero_src_b: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_rs_b == '0) |-> fwd_sel_b == 2'b00);
   a_r6_bubble_eq_stall: assert property (@(posedge clk) disable iff (!rst_n)
      bubble == stall);
   a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (idex_is_load && idex_rd != '0));
   a_r9_thru_a: assert property (@(posedge clk) disable iff (!rst_n)
      (memwb_wen && memwb_rd != '0 && memwb_rd == ifid_rs_a) |-> rf_rdata_a == memwb_wdata);
   a_r9_thru_b: assert property (@(posedge clk) disable iff (!rst_n)
      (memwb_wen && memwb_rd != '0 && memwb_rd == ifid_rs_b) |-> rf_rdata_b == memwb_wdata);
   a_r10_zero_read_a: assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_rs_a == '0) |-> rf_rdata_a == '0);
   a_r10_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_rs_b == '0) |-> rf_rdata_b == '0);
endmodule

bind hzd_bypass_unit hzd_bypass_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .idex_rs_a(idex_rs_a), .idex_rs_b(idex_rs_b), .idex_rd(idex_rd),
   .idex_is_load(idex_is_load), .ifid_rs_a(ifid_rs_a), .ifid_rs_b(ifid_rs_b),
   .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .memwb_rd(memwb_rd),
   .memwb_wen(memwb_wen), .memwb_wdata(memwb_wdata),
   .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .stall(stall), .bubble(bubble),
   .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b)
);

// File: tb/hzd_bypass_unit_tb.sv
module hzd_bypass_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  idex_rs_a = '0, idex_rs_b = '0, idex_rd = '0;
   logic        idex_is_load = 1'b0;
   logic [4:0]  ifid_rs_a = '0, ifid_rs_b = '0;
   logic [4:0]  exmem_rd = '0, memwb_rd = '0;
   logic        exmem_wen = 1'b0, memwb_wen = 1'b0;
   logic [31:0] memwb_wdata = '0;
   logic [1:0]  fwd_sel_a, fwd_sel_b;
   logic        stall, bubble;
   logic [31:0] rf_rdata_a, rf_rdata_b;

   int unsigned model_rf [32];
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   hzd_bypass_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .idex_rs_a(idex_rs_a), .idex_rs_b(idex_rs_b), .idex_rd(idex_rd),
      .idex_is_load(idex_is_load), .ifid_rs_a(ifid_rs_a), .ifid_rs_b(ifid_rs_b),
      .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .memwb_rd(memwb_rd),
      .memwb_wen(memwb_wen), .memwb_wdata(memwb_wdata),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .stall(stall), .bubble(bubble),
      .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b)
   );

   function automatic logic [1:0] want_sel(int src);
      bit m = (src != 0) && exmem_wen && (int'(exmem_rd) == src);
      bit w = (src != 0) && memwb_wen && (int'(memwb_rd) == src);
      if (m) return 2'b10;
      if (w) return 2'b01;
      return 2'b00;
   endfunction

   function automatic string sel_tag(int src);
      bit m = (src != 0) && exmem_wen && (int'(exmem_rd) == src);
      bit w = (src != 0) && memwb_wen && (int'(memwb_rd) == src);
      if (m && w) return "R3";
      if (m) return "R1";
      if (w) return "R2";
      if (src == 0) return "R5";
      return "R4";
   endfunction

   function automatic logic [31:0] want_rd(int a);
      if (a == 0) return 32'd0;
      if (memwb_wen && int'(memwb_rd) == a) return memwb_wdata;
      return model_rf[a];
   endfunction

   function automatic string rd_tag(int a);
      if (a == 0) return "R10";
      if (memwb_wen && int'(memwb_rd) == a) return "R9";
      return "R8";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_now();
      bit exp_stall;
      string st;
      exp_stall = idex_is_load && idex_rd != 0 &&
                  (idex_rd == ifid_rs_a || idex_rd == ifid_rs_b);
      if (exp_stall) st = "R6";
      else if (!idex_is_load && idex_rd != 0 &&
               (idex_rd == ifid_rs_a || idex_rd == ifid_rs_b)) st = "R7";
      else if (idex_rd == 0) st = "R5";
      else st = "R6";
      chk({sel_tag(int'(idex_rs_a)), " sel_a"}, 32'(fwd_sel_a), 32'(want_sel(int'(idex_rs_a))));
      chk({sel_tag(int'(idex_rs_b)), " sel_b"}, 32'(fwd_sel_b), 32'(want_sel(int'(idex_rs_b))));
      chk({st, " stall"}, 32'(stall), 32'(exp_stall));
      chk("R6 bubble", 32'(bubble), 32'(exp_stall));
      chk({rd_tag(int'(ifid_rs_a)), " rdata_a"}, rf_rdata_a, want_rd(int'(ifid_rs_a)));
      chk({rd_tag(int'(ifid_rs_b)), " rdata_b"}, rf_rdata_b, want_rd(int'(ifid_rs_b)));
   endtask

   // drive at negedge, check 2 ns later, commit model write at the next rising edge
   task automatic step(input int xa, input int xb, input int xd, input bit ld,
                       input int fa, input int fb, input int emd, input bit emw,
                       input int mwd, input bit mww, input logic [31:0] wd);
      @(negedge clk);
      idex_rs_a = 5'(xa); idex_rs_b = 5'(xb); idex_rd = 5'(xd); idex_is_load = ld;
      ifid_rs_a = 5'(fa); ifid_rs_b = 5'(fb);
      exmem_rd = 5'(emd); exmem_wen = emw;
      memwb_rd = 5'(mwd); memwb_wen = mww; memwb_wdata = wd;
      #2;
      check_now();
      @(posedge clk);
      if (mww && mwd != 0) model_rf[mwd] = wd;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) model_rf[i] = 0;
      ifid_rs_a = 5'd3; ifid_rs_b = 5'd17;
      #12;
      chk("R11 reset rdata_a", rf_rdata_a, 32'd0);
      chk("R11 reset rdata_b", rf_rdata_b, 32'd0);
      chk("R11 reset stall", 32'(stall), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // producer writes R1; four readers follow
      step(0, 0, 1, 0,  1, 0,  0, 0,  0, 0, 32'h0);          // reader1 in IF/ID
      step(1, 0, 4, 0,  1, 5,  1, 1,  0, 0, 32'h0);          // R1 via EX/MEM
      step(1, 5, 6, 0,  1, 7,  4, 1,  1, 1, 32'hA5A5_0001);  // R2 via MEM/WB, R9 thru
      step(7, 1, 8, 0,  1, 9,  6, 1,  4, 1, 32'h0000_0044);  // R8 stored R1
      // both bypass stages hold R2: R3
      step(2, 2, 3, 0,  0, 0,  2, 1,  2, 1, 32'h2222_2222);
      // register 0 targets: R5 / R10
      step(0, 0, 0, 1,  0, 0,  0, 1,  0, 1, 32'hDEAD_BEEF);
      step(0, 0, 0, 0,  0, 0,  0, 0,  0, 0, 32'h0);
      // load-use: R6 then R7 with the same operands but no load
      step(0, 0, 9, 1,  3, 9,  0, 0,  0, 0, 32'h0);
      step(0, 0, 9, 0,  3, 9,  0, 0,  0, 0, 32'h0);
      step(0, 0, 9, 1,  9, 0,  0, 0,  0, 0, 32'h0);
      // random traffic on four registers
      for (int n = 0; n < 400; n++) begin
         step(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), 1'($urandom),
              int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), 1'($urandom),
              int'($urandom % 4), 1'($urandom), $urandom);
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule